// File: doc/BRIEF.md
# Network Controller Host Register File

This block is the word-wide register file that a host processor uses to steer a network controller. It holds a command register whose bits start the controller's internal engines, an interrupt status register fed by event inputs from those engines, an interrupt mask register and a single level interrupt output. It also holds configuration, control, descriptor pointer and counter registers. Each register follows its own write rule: write-one-to-clear, writes accepted only in reset mode, read-only fields, a low bit forced to zero, or inverted storage.

The host writes through a one-cycle write port: an enable, a register index and a 16-bit word. It reads through a combinational index-to-data port. Accepted command writes produce one-cycle action strobes toward the engines. The engines answer with completion pulses that clear the matching busy command bits, and with event pulses that set status bits. The engines themselves are outside this block.

Top module: `netctl_regs`

## Requirements
- R1: After hardware reset the command register reads 0x0094 (soft-reset bit 7, timer-stop bit 4, receiver-off bit 2). The mask, status, second configuration, sequence and match-enable registers read 0. The end-of-buffer count reads 0x02F8 and the interrupt output is low.
- R2: A 1 on event input bit i sets status bit i. A host write to the status register clears each bit written as 1 and keeps each bit written as 0. When an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R3: The mask register stores bits 14:0 of a write, and bit 15 always reads 0.
- R4: The interrupt output is high exactly when some bit is set in both mask and status, from the cycle after the write or event that changed them.
- R5: The first configuration register (index 1) takes writes only while command bit 7 is set, storing the word AND 0xBFFF. The second configuration register (index 9) follows the same rule with AND 0xF017. Writes made outside reset mode leave both registers unchanged.
- R6: The transmit control register (index 3) stores only bits 15:12 of a write. The receive control register (index 2) stores only the bits in 0xFFE0.
- R7: While command bit 7 is set, a command write with bit 7 clear only clears bit 7. All other bits of that write are ignored and no strobe fires.
- R8: Every other command write ORs the word AND 0x03BF into the command register. Bit 0 is halt, 1 transmit, 2 receiver off, 3 receiver on, 4 timer stop, 5 timer start, 7 soft reset, 8 read resource and 9 load match table.
- R9: Writing receiver-on clears receiver-off and the reverse. Writing timer-start clears timer-stop and the reverse. Neither pair is ever set together.
- R10: A command write with bit 7 set clears bits 0, 1, 3, 8 and 9 and sets bits 7 and 2.
- R11: An accepted command write drives the strobe output with the word AND 0x03BF for exactly the one clock after the write. Completion input bits 0, 1 and 2 clear command bits 1, 8 and 9 respectively.
- R12: The descriptor pointer registers (indices 10 and 11) force bit 0 to zero. The inverted registers (indices 12 and 13) store the bitwise inverse of the written word.
- R13: Register indices 14 to 63 read as zero, and writes to them change no register.
- R14: The end-of-buffer count (6), sequence (7) and match-enable (8) registers store and return the full written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write enable, one word per cycle |
| wr_idx_i | input | IDX_W | Register index of the write |
| wr_data_i | input | 16 | Write data |
| rd_idx_i | input | IDX_W | Register index of the read |
| rd_data_o | output | 16 | Read data, combinational from rd_idx_i |
| evt_i | input | 16 | Event pulses that set status bits |
| done_i | input | 3 | Completion pulses: transmit, read resource, load match table |
| strb_o | output | 16 | One-cycle command action strobes |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 6-bit index, two pointer registers and two inverted registers. This keeps the whole index space of 64 entries small enough to sweep, so every unused index is written and read back. Each of the 16 bit positions is walked through the mask, status, control and pointer write rules. The command register is driven through a fixed sequence covering entry to and exit from reset mode, the exclusive pairs, the completion pulses and a combined soft-reset write. Expected words are computed in the bench from the masks stated in the requirements.

// File: rtl/netctl_pkg.sv
`timescale 1ns/1ps
package netctl_pkg;
  localparam int DW = 16;
  typedef logic [DW-1:0] word_t;

  // command bit positions, decoded by the engines
  localparam int B_HALT   = 0;
  localparam int B_TXGO   = 1;
  localparam int B_RXOFF  = 2;
  localparam int B_RXON   = 3;
  localparam int B_TSTOP  = 4;
  localparam int B_TSTART = 5;
  localparam int B_SRST   = 7;
  localparam int B_RDRES  = 8;
  localparam int B_LDCAM  = 9;

  localparam word_t CMD_WMASK = 16'h03BF;
  localparam word_t CMD_HWRST = 16'h0094;
  localparam word_t CFGA_MASK = 16'hBFFF;
  localparam word_t CFGB_MASK = 16'hF017;
  localparam word_t TXC_MASK  = 16'hF000;
  localparam word_t RXC_MASK  = 16'hFFE0;
  localparam word_t MSK_MASK  = 16'h7FFF;

  // register indices
  localparam int IX_CMD  = 0;
  localparam int IX_CFGA = 1;
  localparam int IX_RXC  = 2;
  localparam int IX_TXC  = 3;
  localparam int IX_MSK  = 4;
  localparam int IX_STA  = 5;
  localparam int IX_EOB  = 6;
  localparam int IX_SEQ  = 7;
  localparam int IX_CAME = 8;
  localparam int IX_CFGB = 9;
  localparam int IX_PTR0 = 10;
endpackage

// File: rtl/netctl_cmd.sv
`timescale 1ns/1ps
module netctl_cmd
  import netctl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_hit_i,
  input  word_t       wdata_i,
  input  logic [2:0]  done_i,
  output word_t       cmd_q_o,
  output word_t       strb_q_o
);
  word_t cmd_q, cmd_nxt, strb_q, strb_nxt;
  logic  cmd_en, accept;

  always_comb begin
    cmd_nxt = cmd_q;
    accept  = 1'b0;
    if (done_i[0]) cmd_nxt[B_TXGO]  = 1'b0;
    if (done_i[1]) cmd_nxt[B_RDRES] = 1'b0;
    if (done_i[2]) cmd_nxt[B_LDCAM] = 1'b0;
    if (wr_hit_i) begin
      if (cmd_q[B_SRST] && !wdata_i[B_SRST]) begin
        cmd_nxt[B_SRST] = 1'b0;          // leave reset mode only
      end else begin
        accept  = 1'b1;
        cmd_nxt = cmd_nxt | (wdata_i & CMD_WMASK);
        if (wdata_i[B_RXOFF])  cmd_nxt[B_RXON]   = 1'b0;
        if (wdata_i[B_RXON])   cmd_nxt[B_RXOFF]  = 1'b0;
        if (wdata_i[B_TSTOP])  cmd_nxt[B_TSTART] = 1'b0;
        if (wdata_i[B_TSTART]) cmd_nxt[B_TSTOP]  = 1'b0;
        if (wdata_i[B_SRST]) begin
          cmd_nxt[B_HALT]  = 1'b0;
          cmd_nxt[B_TXGO]  = 1'b0;
          cmd_nxt[B_RXON]  = 1'b0;
          cmd_nxt[B_RDRES] = 1'b0;
          cmd_nxt[B_LDCAM] = 1'b0;
          cmd_nxt[B_SRST]  = 1'b1;
          cmd_nxt[B_RXOFF] = 1'b1;
        end
      end
    end
    cmd_en   = wr_hit_i | (|done_i);
    strb_nxt = accept ? (wdata_i & CMD_WMASK) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_HWRST;
      strb_q <= '0;
    end else begin
      if (cmd_en) cmd_q <= cmd_nxt;
      strb_q <= strb_nxt;
    end
  end

  assign cmd_q_o  = cmd_q;
  assign strb_q_o = strb_q;
endmodule

// File: rtl/netctl_irq.sv
`timescale 1ns/1ps
module netctl_irq
  import netctl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  msk_wr_i,
  input  logic  sta_wr_i,
  input  word_t wdata_i,
  input  word_t evt_i,
  output word_t msk_q_o,
  output word_t sta_q_o,
  output logic  irq_o
);
  word_t msk_q, msk_nxt, sta_q, sta_nxt;

  assign msk_nxt = wdata_i & MSK_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       msk_q <= '0;
    else if (msk_wr_i) msk_q <= msk_nxt;
  end

  for (genvar b = 0; b < DW; b++) begin : g_sta
    logic bit_en;
    assign bit_en     = evt_i[b] | sta_wr_i;
    assign sta_nxt[b] = evt_i[b] | (sta_q[b] & ~(sta_wr_i & wdata_i[b]));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sta_q[b] <= 1'b0;
      else if (bit_en) sta_q[b] <= sta_nxt[b];
    end
  end

  assign irq_o   = |(msk_q & sta_q);
  assign msk_q_o = msk_q;
  assign sta_q_o = sta_q;
endmodule

// File: rtl/netctl_cfg.sv
`timescale 1ns/1ps
module netctl_cfg
  import netctl_pkg::*;
#(
  parameter int    IDX_W   = 6,
  parameter int    N_PTR   = 2,
  parameter int    N_INV   = 2,
  parameter word_t EOB_RST = 16'h02F8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  word_t            wdata_i,
  input  logic             in_reset_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output word_t            rd_data_o
);
  localparam int INV_BASE = IX_PTR0 + N_PTR;

  function automatic logic hit(input logic [IDX_W-1:0] idx, input int n);
    return idx == IDX_W'(n);
  endfunction

  logic  cfga_en, cfgb_en, rxc_en, txc_en, eob_en, seq_en, came_en;
  word_t cfga_q, cfgb_q, rxc_q, txc_q, eob_q, seq_q, came_q;

  always_comb begin
    cfga_en = wr_en_i && in_reset_i && hit(wr_idx_i, IX_CFGA);
    cfgb_en = wr_en_i && in_reset_i && hit(wr_idx_i, IX_CFGB);
    rxc_en  = wr_en_i && hit(wr_idx_i, IX_RXC);
    txc_en  = wr_en_i && hit(wr_idx_i, IX_TXC);
    eob_en  = wr_en_i && hit(wr_idx_i, IX_EOB);
    seq_en  = wr_en_i && hit(wr_idx_i, IX_SEQ);
    came_en = wr_en_i && hit(wr_idx_i, IX_CAME);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfga_q <= '0;
      cfgb_q <= '0;
      rxc_q  <= '0;
      txc_q  <= '0;
      eob_q  <= EOB_RST;
      seq_q  <= '0;
      came_q <= '0;
    end else begin
      if (cfga_en) cfga_q <= wdata_i & CFGA_MASK;
      if (cfgb_en) cfgb_q <= wdata_i & CFGB_MASK;
      if (rxc_en)  rxc_q  <= wdata_i & RXC_MASK;
      if (txc_en)  txc_q  <= wdata_i & TXC_MASK;
      if (eob_en)  eob_q  <= wdata_i;
      if (seq_en)  seq_q  <= wdata_i;
      if (came_en) came_q <= wdata_i;
    end
  end

  word_t ptr_q [N_PTR];
  word_t inv_q [N_INV];

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    logic  en;
    word_t nxt;
    assign en  = wr_en_i && hit(wr_idx_i, IX_PTR0 + g);
    assign nxt = {wdata_i[DW-1:1], 1'b0};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ptr_q[g] <= '0;
      else if (en) ptr_q[g] <= nxt;
    end
  end

  for (genvar g = 0; g < N_INV; g++) begin : g_inv
    logic  en;
    word_t nxt;
    assign en  = wr_en_i && hit(wr_idx_i, INV_BASE + g);
    assign nxt = ~wdata_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) inv_q[g] <= '0;
      else if (en) inv_q[g] <= nxt;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (hit(rd_idx_i, IX_CFGA)) rd_data_o = cfga_q;
    if (hit(rd_idx_i, IX_CFGB)) rd_data_o = cfgb_q;
    if (hit(rd_idx_i, IX_RXC))  rd_data_o = rxc_q;
    if (hit(rd_idx_i, IX_TXC))  rd_data_o = txc_q;
    if (hit(rd_idx_i, IX_EOB))  rd_data_o = eob_q;
    if (hit(rd_idx_i, IX_SEQ))  rd_data_o = seq_q;
    if (hit(rd_idx_i, IX_CAME)) rd_data_o = came_q;
    for (int k = 0; k < N_PTR; k++)
      if (hit(rd_idx_i, IX_PTR0 + k)) rd_data_o = ptr_q[k];
    for (int k = 0; k < N_INV; k++)
      if (hit(rd_idx_i, INV_BASE + k)) rd_data_o = inv_q[k];
  end
endmodule

// File: rtl/netctl_regs.sv
`timescale 1ns/1ps
module netctl_regs
  import netctl_pkg::*;
#(
  parameter int    IDX_W   = 6,
  parameter int    N_PTR   = 2,
  parameter int    N_INV   = 2,
  parameter word_t EOB_RST = 16'h02F8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [15:0]      wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [15:0]      rd_data_o,
  input  logic [15:0]      evt_i,
  input  logic [2:0]       done_i,
  output logic [15:0]      strb_o,
  output logic             irq_o
);
  word_t cmd_q, msk_q, sta_q, cfg_rd;
  logic  cmd_hit, msk_hit, sta_hit;

  assign cmd_hit = wr_en_i && (wr_idx_i == IDX_W'(IX_CMD));
  assign msk_hit = wr_en_i && (wr_idx_i == IDX_W'(IX_MSK));
  assign sta_hit = wr_en_i && (wr_idx_i == IDX_W'(IX_STA));

  netctl_cmd u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (cmd_hit),
    .wdata_i  (wr_data_i),
    .done_i   (done_i),
    .cmd_q_o  (cmd_q),
    .strb_q_o (strb_o)
  );

  netctl_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .msk_wr_i (msk_hit),
    .sta_wr_i (sta_hit),
    .wdata_i  (wr_data_i),
    .evt_i    (evt_i),
    .msk_q_o  (msk_q),
    .sta_q_o  (sta_q),
    .irq_o    (irq_o)
  );

  netctl_cfg #(
    .IDX_W   (IDX_W),
    .N_PTR   (N_PTR),
    .N_INV   (N_INV),
    .EOB_RST (EOB_RST)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wdata_i    (wr_data_i),
    .in_reset_i (cmd_q[B_SRST]),
    .rd_idx_i   (rd_idx_i),
    .rd_data_o  (cfg_rd)
  );

  always_comb begin
    unique case (1'b1)
      rd_idx_i == IDX_W'(IX_CMD): rd_data_o = cmd_q;
      rd_idx_i == IDX_W'(IX_MSK): rd_data_o = msk_q;
      rd_idx_i == IDX_W'(IX_STA): rd_data_o = sta_q;
      default:                    rd_data_o = cfg_rd;
    endcase
  end
endmodule

// File: rtl/netctl_regs_chk.sv
`timescale 1ns/1ps
module netctl_regs_chk
  import netctl_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic [15:0]      wr_data_i,
  input logic [15:0]      evt_i,
  input logic [2:0]       done_i,
  input logic [15:0]      strb_o,
  input logic [15:0]      cmd_q,
  input logic [15:0]      msk_q,
  input logic [15:0]      sta_q
);
  logic wr_cmd, wr_sta;
  assign wr_cmd = wr_en_i && (wr_idx_i == IDX_W'(IX_CMD));
  assign wr_sta = wr_en_i && (wr_idx_i == IDX_W'(IX_STA));

  a_r2_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sta |=> sta_q == (($past(sta_q) & ~$past(wr_data_i)) | $past(evt_i)));

  a_r3_mask_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msk_q[15] == 1'b0);

  a_r7_exit_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && cmd_q[B_SRST] && !wr_data_i[B_SRST] && done_i == 3'b000)
      |=> (cmd_q == ($past(cmd_q) & ~16'h0080)) && (strb_o == 16'h0000));

  a_r9_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_q[B_RXON] && cmd_q[B_RXOFF]) && !(cmd_q[B_TSTART] && cmd_q[B_TSTOP]));

  a_r10_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && wr_data_i[B_SRST])
      |=> cmd_q[B_SRST] && cmd_q[B_RXOFF] && !cmd_q[B_RXON] &&
          cmd_q[9:8] == 2'b00 && cmd_q[1:0] == 2'b00);

  a_r11_strobe_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|strb_o) |-> $past(wr_cmd));
endmodule

bind netctl_regs netctl_regs_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_idx_i  (wr_idx_i),
  .wr_data_i (wr_data_i),
  .evt_i     (evt_i),
  .done_i    (done_i),
  .strb_o    (strb_o),
  .cmd_q     (cmd_q),
  .msk_q     (msk_q),
  .sta_q     (sta_q)
);

// File: tb/netctl_regs_tb.sv
`timescale 1ns/1ps
module netctl_regs_tb;
  localparam int IDX_W = 6;
  localparam int N_PTR = 2;
  localparam int N_INV = 2;
  localparam int FIRST_FREE = 10 + N_PTR + N_INV;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [15:0]      wr_data;
  logic [IDX_W-1:0] rd_idx;
  logic [15:0]      rd_data;
  logic [15:0]      evt;
  logic [2:0]       done;
  logic [15:0]      strb;
  logic             irq;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [15:0] last_strb;

  always #2 clk = ~clk;

  netctl_regs #(.IDX_W(IDX_W), .N_PTR(N_PTR), .N_INV(N_INV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .evt_i(evt), .done_i(done), .strb_o(strb), .irq_o(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    last_strb = strb;
  endtask

  task automatic rd(input int idx, output logic [15:0] d);
    rd_idx = IDX_W'(idx);
    #1;
    d = rd_data;
  endtask

  task automatic pulse(input logic [15:0] e, input logic [2:0] dn);
    @(negedge clk);
    evt = e; done = dn;
    @(negedge clk);
    evt = '0; done = '0;
  endtask

  task automatic cmd_step(input string req, input logic [15:0] d,
                          input logic [15:0] exp_cmd, input logic [15:0] exp_strb);
    logic [15:0] v;
    wr(0, d);
    rd(0, v);
    check({req, " cmd"}, v, exp_cmd);
    check({req, " strobe"}, last_strb, exp_strb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_idx = '0; evt = '0; done = '0; last_strb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(0, v);  check("R1 cmd", v, 16'h0094);
    rd(4, v);  check("R1 mask", v, 16'h0000);
    rd(5, v);  check("R1 status", v, 16'h0000);
    rd(9, v);  check("R1 cfgb", v, 16'h0000);
    rd(7, v);  check("R1 seq", v, 16'h0000);
    rd(8, v);  check("R1 match-enable", v, 16'h0000);
    rd(6, v);  check("R1 eob", v, 16'h02F8);
    check("R1 irq", {15'd0, irq}, 16'h0000);
    check("R1 strobe", strb, 16'h0000);

    // R5 reset-mode writes accepted
    wr(1, 16'hFFFF); rd(1, v); check("R5 cfga in reset", v, 16'hBFFF);
    wr(9, 16'hFFFF); rd(9, v); check("R5 cfgb in reset", v, 16'hF017);
    wr(1, 16'h4321); rd(1, v); check("R5 cfga pattern", v, 16'h4321 & 16'hBFFF);

    // R7 exit from reset ignores the other bits
    cmd_step("R7", 16'h0008, 16'h0014, 16'h0000);

    // R5 writes outside reset mode ignored
    wr(1, 16'h1234); rd(1, v); check("R5 cfga locked", v, 16'h0321);
    wr(9, 16'h0000); rd(9, v); check("R5 cfgb locked", v, 16'hF017);

    // R8 R9 R11 command sequence
    cmd_step("R9 rxon", 16'h0008, 16'h0018, 16'h0008);
    cmd_step("R9 tstart", 16'h0020, 16'h0028, 16'h0020);
    cmd_step("R9 rxoff", 16'h0004, 16'h0024, 16'h0004);
    cmd_step("R8 tx+tstop", 16'h0012, 16'h0016, 16'h0012);
    pulse('0, 3'b001); rd(0, v); check("R11 tx done", v, 16'h0014);
    cmd_step("R8 dma pair", 16'h0300, 16'h0314, 16'h0300);
    pulse('0, 3'b110); rd(0, v); check("R11 dma done", v, 16'h0014);
    cmd_step("R8 masked bits", 16'hFC40, 16'h0014, 16'h0000);
    cmd_step("R8 halt+rxon", 16'h0009, 16'h0019, 16'h0009);
    cmd_step("R9 both rx", 16'h000C, 16'h0011, 16'h000C);
    cmd_step("R10 soft reset", 16'h0382, 16'h0094, 16'h0382);
    cmd_step("R7 exit again", 16'h0000, 16'h0014, 16'h0000);
    check("R11 strobe gone", strb, 16'h0000);

    // R6 and R3 bit sweeps
    for (int b = 0; b < 16; b++) begin
      wr(3, 16'(1 << b)); rd(3, v); check("R6 txctl", v, 16'(1 << b) & 16'hF000);
      wr(2, 16'(1 << b)); rd(2, v); check("R6 rxctl", v, 16'(1 << b) & 16'hFFE0);
      wr(4, 16'(1 << b)); rd(4, v); check("R3 mask", v, 16'(1 << b) & 16'h7FFF);
    end

    // R2 R4 status and interrupt sweep
    wr(4, 16'hFFFF);
    for (int b = 0; b < 16; b++) begin
      pulse(16'(1 << b), 3'b000);
      rd(5, v); check("R2 set", v, 16'(1 << b));
      check("R4 irq on", {15'd0, irq}, (b == 15) ? 16'h0000 : 16'h0001);
      wr(5, ~16'(1 << b)); rd(5, v); check("R2 zeros keep", v, 16'(1 << b));
      wr(5, 16'(1 << b));  rd(5, v); check("R2 clear", v, 16'h0000);
      check("R4 irq off", {15'd0, irq}, 16'h0000);
    end
    // set wins over clear in the same cycle
    @(negedge clk);
    evt = 16'h0008; wr_en = 1'b1; wr_idx = IDX_W'(5); wr_data = 16'h0008;
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
    rd(5, v); check("R2 set beats clear", v, 16'h0008);
    wr(4, 16'h0000); check("R4 masked off", {15'd0, irq}, 16'h0000);
    wr(4, 16'h0008); check("R4 mask on", {15'd0, irq}, 16'h0001);
    wr(5, 16'h0008);

    // R12 pointers and inverted registers
    for (int b = 0; b < 16; b++) begin
      wr(10, 16'(1 << b)); rd(10, v); check("R12 ptr0", v, 16'(1 << b) & 16'hFFFE);
      wr(11, 16'hA5A5 ^ 16'(1 << b)); rd(11, v);
      check("R12 ptr1", v, (16'hA5A5 ^ 16'(1 << b)) & 16'hFFFE);
      wr(12, 16'(1 << b)); rd(12, v); check("R12 inv0", v, ~16'(1 << b));
      wr(13, 16'h5A5A ^ 16'(1 << b)); rd(13, v);
      check("R12 inv1", v, ~(16'h5A5A ^ 16'(1 << b)));
    end

    // R14 plain registers
    wr(6, 16'h1234); rd(6, v); check("R14 eob", v, 16'h1234);
    wr(7, 16'hBEEF); rd(7, v); check("R14 seq", v, 16'hBEEF);
    wr(8, 16'hFFFF); rd(8, v); check("R14 match-enable", v, 16'hFFFF);

    // R13 unused indices
    for (int i = FIRST_FREE; i < (1 << IDX_W); i++) begin
      wr(i, 16'hFFFF); rd(i, v); check("R13 unused read", v, 16'h0000);
    end
    rd(0, v);  check("R13 cmd kept", v, 16'h0014);
    rd(4, v);  check("R13 mask kept", v, 16'h0008);
    rd(5, v);  check("R13 status kept", v, 16'h0000);
    rd(13, v); check("R13 inv kept", v, ~(16'h5A5A ^ 16'h8000));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule